// File: doc/BRIEF.md
# Fabric Configuration Handshake Sequencer

This block runs the control side of a full passive-parallel load of an attached programmable fabric. After a start pulse it first rejects a mode-select setting that is not a parallel load. It then makes sure no other agent holds the configuration lines, takes ownership of the control drives and drops chip-select. It pulses the active-low configuration request and follows the active-low status line down and back up, and confirms that the completion line sits low with its output enable high.

Only then does it open the data-path and clock-path enables. An external streamer moves the bitstream and signals the end of the stream. The sequencer waits for the completion line, and aborts if the status line collapses during that wait. It then requests a fixed burst of trailing configuration clocks and waits for the fabric's user-mode flag. As the last step it hands every drive back, raises chip-select and judges the outcome on the three status inputs.

Every wait is bounded by a cycle timeout, and each way of failing has its own error code. After an error or a success the block sits idle with all drives released. It keeps the result until the next start.

Top module: `fcs_config_seq`

## Requirements
- R1: On a start pulse in idle, a mode-select value with any bit above bit 0 set leaves the block idle and sets error code 1. A value of 0 or 1 starts the sequence and clears the error code to 0 and the done flag.
- R2: Before the reset pulse the block waits, with drives released, until both the external configuration-request pin and the status pin read high. It then takes ownership (request drive enable and configuration drive enable high, chip-select low) and waits for both pins to read high again.
- R3: The reset step drives the configuration request low until the status pin reads low. It then drives it high until the status pin reads high. The request is driven low only while the block owns that drive.
- R4: After the reset step, a completion line reading high or its output enable reading low ends the run with error code 6.
- R5: The data and clock enables are high only from the cycle after a successful post-reset check until user mode is seen. They are high only while the block owns the drives.
- R6: While the block waits for the completion line after the stream, a status pin reading low (with the completion line still low) ends the run with error code 7.
- R7: After the completion line is seen, the extra-clock output is high for exactly EXTRA_CLKS consecutive cycles (default 15). After that the block waits for user mode with the enables still high.
- R8: After user mode the block spends one cycle with all drives released and chip-select high. It sets the done flag only if user mode, the completion line and the status pin all read high in that cycle. Otherwise it sets error code 10.
- R9: Each wait fails after TIMEOUT_CYC cycles without its condition, with its own error code: first pin wait 2, second pin wait 3, status-low wait 4, status-high wait 5, completion wait 8, user-mode wait 9. The stream wait has no timeout.
- R10: In idle all drives are released: chip-select high, drive enables low, data, clock and extra-clock outputs low. The error code and the done flag keep their values until the next start pulse.
- R11: A start pulse while the block is busy has no effect.
- R12: After reset the block is idle with error code 0 and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a configuration run |
| data_done_i | input | 1 | Streamer signals that the last data word was sent |
| mode_sel_i | input | MSEL_W | Mode-select pins of the fabric |
| ncfg_pin_i | input | 1 | Readback of the external configuration-request pin (active low) |
| nstat_pin_i | input | 1 | Fabric status pin (active low) |
| cdone_pin_i | input | 1 | Fabric configuration-complete pin |
| cdone_oe_i | input | 1 | Output enable of the completion pin as reported by the fabric |
| user_mode_i | input | 1 | Fabric reports user mode |
| ncfg_drv_o | output | 1 | Level driven on the configuration request (0 = request reset) |
| ncfg_oe_o | output | 1 | Drive enable for the configuration request |
| cfg_oe_o | output | 1 | Drive enable for the configuration control lines |
| nce_o | output | 1 | Chip-select to the fabric, active low |
| data_en_o | output | 1 | Data-path enable for the streamer |
| ctrl_en_o | output | 1 | Configuration clock-path enable |
| extra_clk_o | output | 1 | One trailing configuration clock requested per high cycle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run succeeded |
| err_code_o | output | 4 | Error code of the last run, 0 when none |

## Verification
A behavioural model of the fabric answers the configuration request on the status pin after a short delay. It can also be told to pin the status line high or low, and the bench drives the other status inputs by hand. Clean runs with mode values 0 and 1, with a start pulse injected mid-stream, separate a correct handshake and burst length from a sequencer that reacts to stray starts or miscounts clocks. Runs with one fault each are checked for their exact error code and for released drives afterwards. The faults are a held request pin, a status line stuck high or collapsing during the completion wait, a completion line that is high or lacks its enable, missing completion or user mode, and an inconsistent final status. Together they show that every exit path is distinct. An illegal mode value shows that the block refuses to start at all.

// File: rtl/fcs_pkg.sv
// Package: shared state encoding and error codes of the configuration
// sequencer. Assumes a 4-bit error code field.
package fcs_pkg;

    localparam int ERR_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_WAIT,
        ST_OWN_WAIT,
        ST_RST_LOW,
        ST_RST_HIGH,
        ST_RST_CHECK,
        ST_STREAM,
        ST_WAIT_CDONE,
        ST_BURST,
        ST_WAIT_USER,
        ST_FINISH
    } seq_state_e;

    localparam logic [ERR_W-1:0] E_NONE        = 4'd0;
    localparam logic [ERR_W-1:0] E_MODE        = 4'd1;
    localparam logic [ERR_W-1:0] E_PRE_TO      = 4'd2;
    localparam logic [ERR_W-1:0] E_OWN_TO      = 4'd3;
    localparam logic [ERR_W-1:0] E_RLO_TO      = 4'd4;
    localparam logic [ERR_W-1:0] E_RHI_TO      = 4'd5;
    localparam logic [ERR_W-1:0] E_RST_CHK     = 4'd6;
    localparam logic [ERR_W-1:0] E_NSTAT_ABORT = 4'd7;
    localparam logic [ERR_W-1:0] E_CDONE_TO    = 4'd8;
    localparam logic [ERR_W-1:0] E_USER_TO     = 4'd9;
    localparam logic [ERR_W-1:0] E_FINAL       = 4'd10;

endpackage

// File: rtl/fcs_wait_timer.sv
// Module: per-state wait counter. It counts the cycles spent in the current
// state and flags the last allowed cycle. Assumes clr_i is high on every
// state change, so the count restarts at zero on entry to a state.
module fcs_wait_timer #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);
    localparam int TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Count cycles in the current state, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final cycle of the wait window.
    always_comb expired_o = (cnt_q == LAST);

endmodule

// File: rtl/fcs_clk_burst.sv
// Module: trailing-clock burst counter. While en_i is high it counts cycles
// and raises last_o on the N-th cycle. Assumes en_i stays high until last_o
// has been seen and then drops.
module fcs_clk_burst #(
    parameter int N = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic last_o
);
    localparam int BW = $clog2(N + 1);
    localparam logic [BW-1:0] LAST = BW'(N - 1);

    logic [BW-1:0] cnt_q;

    // Count burst cycles; clear whenever the burst is not active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // Mark the last requested clock of the burst.
    always_comb last_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/fcs_drive_map.sv
// Module: maps the sequencer state to the pin drives and enables. Pure
// decode of a registered state, so the outputs carry no input-to-output path.
module fcs_drive_map
    import fcs_pkg::*;
(
    input  seq_state_e state_i,
    output logic       ncfg_drv_o,
    output logic       ncfg_oe_o,
    output logic       cfg_oe_o,
    output logic       nce_o,
    output logic       data_en_o,
    output logic       ctrl_en_o,
    output logic       extra_clk_o,
    output logic       busy_o
);
    logic owned;
    logic streaming;

    // Decide which states own the drives and which open the data path.
    always_comb begin
        owned     = 1'b0;
        streaming = 1'b0;
        unique case (state_i)
            ST_OWN_WAIT, ST_RST_LOW, ST_RST_HIGH, ST_RST_CHECK: owned = 1'b1;
            ST_STREAM, ST_WAIT_CDONE, ST_BURST, ST_WAIT_USER: begin
                owned     = 1'b1;
                streaming = 1'b1;
            end
            default: ;
        endcase
    end

    // Translate ownership and phase into the individual pins.
    always_comb begin
        ncfg_oe_o   = owned;
        cfg_oe_o    = owned;
        nce_o       = !owned;
        ncfg_drv_o  = (state_i != ST_RST_LOW);
        data_en_o   = streaming;
        ctrl_en_o   = streaming;
        extra_clk_o = (state_i == ST_BURST);
        busy_o      = (state_i != ST_IDLE);
    end

endmodule

// File: rtl/fcs_config_seq.sv
// Module: top of the fabric configuration handshake sequencer. It steps
// through mode check, ownership, the reset pulse, streaming, the completion
// wait, the trailing clock burst, the user-mode wait and release. Assumes all
// status inputs are already synchronised to clk.
module fcs_config_seq
    import fcs_pkg::*;
#(
    parameter int MSEL_W      = 3,
    parameter int TIMEOUT_CYC = 1024,
    parameter int EXTRA_CLKS  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              data_done_i,
    input  logic [MSEL_W-1:0] mode_sel_i,
    input  logic              ncfg_pin_i,
    input  logic              nstat_pin_i,
    input  logic              cdone_pin_i,
    input  logic              cdone_oe_i,
    input  logic              user_mode_i,
    output logic              ncfg_drv_o,
    output logic              ncfg_oe_o,
    output logic              cfg_oe_o,
    output logic              nce_o,
    output logic              data_en_o,
    output logic              ctrl_en_o,
    output logic              extra_clk_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [3:0]        err_code_o
);
    localparam logic [MSEL_W-1:0] MSEL_OK_MASK = MSEL_W'(1);

    seq_state_e       state_q, state_d;
    logic [ERR_W-1:0] err_q;
    logic             done_q;
    logic             fail;
    logic [ERR_W-1:0] fail_code;
    logic             succeed;
    logic             tmo;
    logic             burst_last;
    logic             mode_bad;
    logic             lines_free;

    // Derive the start-time mode test and the shared free-lines test.
    always_comb begin
        mode_bad   = (mode_sel_i & ~MSEL_OK_MASK) != '0;
        lines_free = ncfg_pin_i && nstat_pin_i;
    end

    // Next-state logic with per-step timeout and failure selection.
    always_comb begin
        state_d   = state_q;
        fail      = 1'b0;
        fail_code = E_NONE;
        succeed   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && !mode_bad) state_d = ST_PRE_WAIT;
            end
            ST_PRE_WAIT: begin
                if (lines_free) state_d = ST_OWN_WAIT;
                else if (tmo) begin fail = 1'b1; fail_code = E_PRE_TO; end
            end
            ST_OWN_WAIT: begin
                if (lines_free) state_d = ST_RST_LOW;
                else if (tmo) begin fail = 1'b1; fail_code = E_OWN_TO; end
            end
            ST_RST_LOW: begin
                if (!nstat_pin_i) state_d = ST_RST_HIGH;
                else if (tmo) begin fail = 1'b1; fail_code = E_RLO_TO; end
            end
            ST_RST_HIGH: begin
                if (nstat_pin_i) state_d = ST_RST_CHECK;
                else if (tmo) begin fail = 1'b1; fail_code = E_RHI_TO; end
            end
            ST_RST_CHECK: begin
                if (!cdone_pin_i && cdone_oe_i) state_d = ST_STREAM;
                else begin fail = 1'b1; fail_code = E_RST_CHK; end
            end
            ST_STREAM: begin
                if (data_done_i) state_d = ST_WAIT_CDONE;
            end
            ST_WAIT_CDONE: begin
                if (cdone_pin_i) state_d = ST_BURST;
                else if (!nstat_pin_i) begin fail = 1'b1; fail_code = E_NSTAT_ABORT; end
                else if (tmo) begin fail = 1'b1; fail_code = E_CDONE_TO; end
            end
            ST_BURST: begin
                if (burst_last) state_d = ST_WAIT_USER;
            end
            ST_WAIT_USER: begin
                if (user_mode_i) state_d = ST_FINISH;
                else if (tmo) begin fail = 1'b1; fail_code = E_USER_TO; end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
                if (user_mode_i && cdone_pin_i && nstat_pin_i) succeed = 1'b1;
                else begin fail = 1'b1; fail_code = E_FINAL; end
            end
            default: state_d = ST_IDLE;
        endcase
        if (fail) state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result register: cleared or set to the mode error on start, updated at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= E_NONE;
            done_q <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            err_q  <= mode_bad ? E_MODE : E_NONE;
            done_q <= 1'b0;
        end else if (fail) begin
            err_q  <= fail_code;
        end else if (succeed) begin
            done_q <= 1'b1;
        end
    end

    fcs_wait_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) wait_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_d != state_q),
        .expired_o(tmo)
    );

    fcs_clk_burst #(
        .N(EXTRA_CLKS)
    ) burst_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (state_q == ST_BURST),
        .last_o(burst_last)
    );

    fcs_drive_map drive_i (
        .state_i    (state_q),
        .ncfg_drv_o (ncfg_drv_o),
        .ncfg_oe_o  (ncfg_oe_o),
        .cfg_oe_o   (cfg_oe_o),
        .nce_o      (nce_o),
        .data_en_o  (data_en_o),
        .ctrl_en_o  (ctrl_en_o),
        .extra_clk_o(extra_clk_o),
        .busy_o     (busy_o)
    );

    // Present the result registers.
    always_comb begin
        done_o     = done_q;
        err_code_o = err_q;
    end

endmodule

// File: rtl/fcs_config_seq_chk.sv
// Module: property checker for the configuration sequencer, bound to the top
// module. It observes ports only; one counter measures the burst length.
module fcs_config_seq_chk #(
    parameter int MSEL_W     = 3,
    parameter int EXTRA_CLKS = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [MSEL_W-1:0] mode_sel_i,
    input logic              nstat_pin_i,
    input logic              cdone_pin_i,
    input logic              user_mode_i,
    input logic              ncfg_drv_o,
    input logic              ncfg_oe_o,
    input logic              cfg_oe_o,
    input logic              nce_o,
    input logic              data_en_o,
    input logic              ctrl_en_o,
    input logic              extra_clk_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [3:0]        err_code_o
);
    int unsigned run_q;

    // Length of the current run of extra-clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= 0;
        else if (extra_clk_o) run_q <= run_q + 1;
        else                  run_q <= 0;
    end

    p_mode_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && ((mode_sel_i >> 1) != '0)) |=> (!busy_o && err_code_o == 4'd1));

    p_low_only_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ncfg_drv_o |-> ncfg_oe_o);

    p_enables_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en_o || ctrl_en_o) |-> (!nce_o && ncfg_oe_o && cfg_oe_o && ncfg_drv_o));

    p_burst_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(extra_clk_o) |-> (run_q == EXTRA_CLKS));

    p_burst_in_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        extra_clk_o |-> data_en_o);

    p_success_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(user_mode_i && cdone_pin_i && nstat_pin_i));

    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (nce_o && !ncfg_oe_o && !cfg_oe_o && !data_en_o && !ctrl_en_o && !extra_clk_o));

    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(err_code_o) && $stable(done_o)));

    p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_code_o == 4'd0));

endmodule

bind fcs_config_seq fcs_config_seq_chk #(
    .MSEL_W    (MSEL_W),
    .EXTRA_CLKS(EXTRA_CLKS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_sel_i (mode_sel_i),
    .nstat_pin_i(nstat_pin_i),
    .cdone_pin_i(cdone_pin_i),
    .user_mode_i(user_mode_i),
    .ncfg_drv_o (ncfg_drv_o),
    .ncfg_oe_o  (ncfg_oe_o),
    .cfg_oe_o   (cfg_oe_o),
    .nce_o      (nce_o),
    .data_en_o  (data_en_o),
    .ctrl_en_o  (ctrl_en_o),
    .extra_clk_o(extra_clk_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_code_o (err_code_o)
);

// File: tb/fcs_config_seq_tb_top.sv
// Bench: behavioural fabric, cycle-by-cycle reference model compared on every
// clock, plus directed scenarios with named checks.
module fcs_config_seq_tb_top;
    localparam int MSEL_W = 3;
    localparam int TMO    = 64;
    localparam int NCLK   = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, ddone = 1'b0;
    logic [MSEL_W-1:0] msel = '0;
    logic ncfgpin = 1'b1, stat = 1'b1, cd = 1'b0, cdoe = 1'b1, um = 1'b0;
    logic ncfg_drv, ncfg_oe, cfg_oe, nce, data_en, ctrl_en, extra_clk, busy, done;
    logic [3:0] err;

    int checks = 0, fails = 0;
    int smode = 0;          // 0 follow request, 1 stuck high, 2 forced low
    logic [1:0] pipe = '0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    fcs_config_seq #(.MSEL_W(MSEL_W), .TIMEOUT_CYC(TMO), .EXTRA_CLKS(NCLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .data_done_i(ddone),
        .mode_sel_i(msel), .ncfg_pin_i(ncfgpin), .nstat_pin_i(stat),
        .cdone_pin_i(cd), .cdone_oe_i(cdoe), .user_mode_i(um),
        .ncfg_drv_o(ncfg_drv), .ncfg_oe_o(ncfg_oe), .cfg_oe_o(cfg_oe), .nce_o(nce),
        .data_en_o(data_en), .ctrl_en_o(ctrl_en), .extra_clk_o(extra_clk),
        .busy_o(busy), .done_o(done), .err_code_o(err));

    // Fabric model: status line follows the driven-low request after two cycles.
    always @(negedge clk) begin
        pipe = {pipe[0], (ncfg_oe && !ncfg_drv)};
        case (smode)
            0:       stat = !pipe[1];
            1:       stat = 1'b1;
            default: stat = 1'b0;
        endcase
    end

    // Reference model of the sequence, phases as plain integers.
    int m_ph = 0, m_cnt = 0;
    int m_err = 0;
    bit m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_err = 0; m_done = 0;
        end else begin
            int nx;
            int fc;
            nx = m_ph; fc = 0;
            case (m_ph)
                0: if (start) begin
                       m_done = 0;
                       if ((msel >> 1) != 0) m_err = 1;
                       else begin m_err = 0; nx = 1; end
                   end
                1: if (ncfgpin && stat) nx = 2; else if (m_cnt == TMO-1) fc = 2;
                2: if (ncfgpin && stat) nx = 3; else if (m_cnt == TMO-1) fc = 3;
                3: if (!stat) nx = 4; else if (m_cnt == TMO-1) fc = 4;
                4: if (stat) nx = 5; else if (m_cnt == TMO-1) fc = 5;
                5: if (!cd && cdoe) nx = 6; else fc = 6;
                6: if (ddone) nx = 7;
                7: if (cd) nx = 8; else if (!stat) fc = 7; else if (m_cnt == TMO-1) fc = 8;
                8: if (m_cnt == NCLK-1) nx = 9;
                9: if (um) nx = 10; else if (m_cnt == TMO-1) fc = 9;
                default: begin
                    nx = 0;
                    if (um && cd && stat) m_done = 1; else fc = 10;
                end
            endcase
            if (fc != 0) begin m_err = fc; nx = 0; end
            if (nx != m_ph) begin m_ph = nx; m_cnt = 0; end
            else if (m_cnt < TMO-1) m_cnt = m_cnt + 1;
        end
    end

    function automatic logic [13:0] model_vec();
        bit own, en;
        own = (m_ph >= 2 && m_ph <= 9);
        en  = (m_ph >= 6 && m_ph <= 9);
        return {m_ph != 0, !own, own, own, m_ph != 3, en, en, m_ph == 8, m_done, 4'(m_err)};
    endfunction

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [13:0] act;
            act = {busy, nce, ncfg_oe, cfg_oe, ncfg_drv, data_en, ctrl_en, extra_clk, done, err};
            checks++;
            if (act !== model_vec()) begin
                fails++;
                $display("FAIL cycle compare (R2 R3 R5 R10 R11): actual %b expected %b at %0t",
                         act, model_vec(), $time);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restore();
        @(negedge clk);
        ncfgpin = 1; smode = 0; cd = 0; cdoe = 1; um = 0; msel = '0; ddone = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        chk(!busy, "R9 run ends", busy, 0);
    endtask

    task automatic wait_stream();
        for (int i = 0; i < 200 && !data_en; i++) @(negedge clk);
        chk(data_en, "R5 stream opens", data_en, 1);
    endtask

    task automatic stream_end();
        repeat (4) @(negedge clk);
        ddone = 1; @(negedge clk); ddone = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic count_burst(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (extra_clk) n++;
            if (n > 0 && !extra_clk) break;
        end
    endtask

    task automatic check_error(input int code, input string req);
        chk(err == code, req, err, code);
        chk(nce && !ncfg_oe && !cfg_oe && !data_en, "R10 drives released", {nce, ncfg_oe, cfg_oe, data_en}, 4'b1000);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog (R9): actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(!busy && nce && err == 0 && !done, "R12 reset state", {busy, nce, err}, 6'b010000);

        // R1 illegal mode refused
        restore(); msel = 3'b100; pulse_start();
        chk(err == 1 && !busy, "R1 mode reject", err, 1);

        // Clean run, mode 0 (R2 R3 R5 R7 R8)
        restore(); pulse_start();
        @(negedge clk);
        chk(err == 0, "R1 start clears code", err, 0);
        wait_stream();
        stream_end(); cd = 1;
        count_burst(n);
        chk(n == NCLK, "R7 extra clock count", n, NCLK);
        chk(data_en, "R7 enables kept in user wait", data_en, 1);
        um = 1;
        wait_idle();
        chk(done && err == 0, "R8 success", done, 1);
        chk(!data_en && nce, "R5 enables closed", data_en, 0);

        // Clean run, mode 1, stray start mid-stream (R11)
        restore(); msel = 3'b001; pulse_start();
        wait_stream();
        pulse_start();
        @(negedge clk);
        chk(busy && data_en && err == 0, "R11 start ignored while busy", data_en, 1);
        stream_end(); cd = 1;
        count_burst(n);
        um = 1;
        wait_idle();
        chk(done, "R11 run completes", done, 1);

        // R9 first pin wait timeout, code held afterwards (R10)
        restore(); ncfgpin = 0; pulse_start();
        wait_idle();
        check_error(2, "R9 pre-wait timeout");
        repeat (6) @(negedge clk);
        chk(err == 2, "R10 code held", err, 2);

        // R3/R9 status never falls
        restore(); smode = 1; pulse_start();
        wait_idle();
        check_error(4, "R3 status-low timeout");

        // R4 completion line high after reset
        restore(); cd = 1; pulse_start();
        wait_idle();
        check_error(6, "R4 completion high");

        // R4 completion enable missing
        restore(); cdoe = 0; pulse_start();
        wait_idle();
        check_error(6, "R4 completion enable low");

        // R6 status collapses during completion wait
        restore(); pulse_start();
        wait_stream(); stream_end();
        smode = 2;
        wait_idle();
        check_error(7, "R6 status abort");

        // R9 completion never arrives
        restore(); pulse_start();
        wait_stream(); stream_end();
        wait_idle();
        check_error(8, "R9 completion timeout");

        // R9 user mode never arrives
        restore(); pulse_start();
        wait_stream(); stream_end(); cd = 1;
        count_burst(n);
        wait_idle();
        check_error(9, "R9 user-mode timeout");

        // R8 final status inconsistent
        restore(); pulse_start();
        wait_stream(); stream_end(); cd = 1;
        count_burst(n);
        um = 1; cd = 0;
        wait_idle();
        check_error(10, "R8 final check fails");
        chk(!done, "R8 no done on failure", done, 0);

        restore();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule